// File: doc/BRIEF.md
# Auto-Buffered Synchronous Serial Port

The block is a three-wire synchronous serial port (serial clock, data out, data in) with a small local byte buffer. Software can send one byte at a time through a data register. It can also start an automatic run that walks a transfer address counter up from zero through the buffer. Each buffer entry is shifted out and, when reception is on, replaced in place with the byte received. The run ends at a programmed end address, or in repeat mode the counter wraps to zero and the run begins again.

An 8-bit mode register, written through a per-bit write mask, selects the unit enable, the transfer style, master or slave clocking, the transmit and receive gates and the bit order. Clearing the enable bit acts as an asynchronous reset of everything in the unit except the mode register itself, and the buffer contents are lost. In master mode the serial clock is the system clock divided by `DIV`. In slave mode the external clock passes through a two-flop synchronizer before edge detection. In both modes the clock idles high, data changes on the falling edge and input is sampled on the rising edge.

Bus map (`addr_i`, width log2(DEPTH)+1): with the top bit clear the low bits index the buffer. With it set, the two low bits pick mode (0), end address (1), data (2) or control/status (3). A control/status read returns `{busy, 0.., counter}`.

Top module: `sync_serial_autobuf`

## Requirements
- R1: The mode register resets to 0x00. A write updates only the bits set in `wmask_i`, and bit 0 always reads 0. Mode bits: 7 enable, 6 automatic, 5 repeat, 4 master, 3 transmit enable, 2 receive enable, 1 LSB-first.
- R2: While enable is 0, `sdo_o` is 0, `sck_o` is 1 and `busy_o` is 0.
- R3: Clearing enable resets the end address, the received-data register, the transfer counter and busy, so all of them read 0 after the unit is enabled again.
- R4: While enable is 0, buffer reads return 0 and buffer writes are dropped. An entry written before a disable reads 0 after re-enable until it is rewritten.
- R5: In master mode a byte is 8 serial clock periods of `DIV` system cycles each. The clock idles high, the first falling edge comes `DIV/2` cycles after start, and `sck_o` is high whenever busy is low.
- R6: With mode bit 1 at 0 the bits go out and come in MSB first. With it at 1 they go LSB first.
- R7: With transmit enable at 0, `sdo_o` stays 0 for the whole transfer.
- R8: With receive enable at 0, the received byte is not stored: the data register (one-byte mode) and the buffer (automatic mode) keep their values.
- R9: A write to the data register (automatic off, not busy) starts a byte. `done_o` pulses for one cycle 8*DIV+1 cycles after the write edge, busy falls on that same edge, and the data register then holds the received byte.
- R10: In single automatic mode, writing 1 to control bit 0 transfers entries 0 through the end address, each replaced by its received byte. A run of N bytes raises one `done_o` pulse N*(8*DIV+2) cycles after the start edge, with busy falling there.
- R11: In repeat automatic mode, each pass raises `done_o` as in R10, then the counter is 0 and busy stays high while the next pass starts at entry 0.
- R12: In slave mode the unit shifts on `sck_i` edges after synchronization, with the same edge roles as in master mode, and `sck_o` stays high.
- R13: The end address register is log2(DEPTH) bits wide, and its unused upper read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | log2(DEPTH)+1 | Bus address (buffer or register) |
| wr_en_i | input | 1 | Bus write strobe |
| wmask_i | input | 8 | Per-bit write enable |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data (combinational on addr_i) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A one-byte master transfer must show `done_o` exactly 8*DIV+1 edges after the write edge. An automatic run of N bytes must show it N*(8*DIV+2) edges after the start. The bench counts edges from the capturing edge and checks the pulse position, the busy level on that cycle and the drop of the pulse one edge later. Bus reads are combinational, so register and buffer values are compared in the same cycle the address is applied. This lets the repeat-mode counter and the refilled entries be read at the moment a pass ends, before the next pass touches them. In slave mode each output bit is sampled at the end of the low half of `sck_i`, which stays well past the synchronizer delay of three system cycles.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned M_EN   = 7;
  localparam int unsigned M_AUTO = 6;
  localparam int unsigned M_RPT  = 5;
  localparam int unsigned M_MST  = 4;
  localparam int unsigned M_TXE  = 3;
  localparam int unsigned M_RXE  = 2;
  localparam int unsigned M_LSB  = 1;

  localparam logic [1:0] REG_MODE = 2'd0;
  localparam logic [1:0] REG_END  = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOAD = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ssa_sck_gen.sv
module ssa_sck_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic active_i,
  input  logic sck_i,
  output logic sck_o,
  output logic fall_o,
  output logic rise_o
);
  localparam int unsigned HALF = (DIV < 2) ? 1 : DIV / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic [2:0]    sync_q;
  logic          tick;
  logic          m_fall, m_rise, s_fall, s_rise;

  assign tick = active_i && master_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sck_q  <= 1'b1;
      sync_q <= 3'b111;
    end else begin
      sync_q <= {sync_q[1:0], sck_i};
      if (!active_i || !master_i) begin
        cnt_q <= '0;
        sck_q <= 1'b1;
      end else if (tick) begin
        cnt_q <= '0;
        sck_q <= ~sck_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign m_fall = tick && sck_q;
  assign m_rise = tick && !sck_q;
  // slave edges seen on the two-flop synchronized copy
  assign s_fall = sync_q[2] && !sync_q[1];
  assign s_rise = !sync_q[2] && sync_q[1];

  assign fall_o = master_i ? m_fall : s_fall;
  assign rise_o = master_i ? m_rise : s_rise;
  assign sck_o  = sck_q;

  AST_SCK_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> sck_q); // R5

endmodule

// File: rtl/ssa_shift_eng.sv
module ssa_shift_eng import ssa_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              lsb_first_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic              sdi_i,
  output logic              active_o,
  output logic              sdo_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rx_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              active_q;
  logic              sdo_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      sdo_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        sh_q     <= tx_i;
        cnt_q    <= '0;
        active_q <= 1'b1;
      end else if (active_q) begin
        if (fall_i) begin
          sdo_q <= lsb_first_i ? sh_q[0] : sh_q[BYTE_W-1];
        end else if (rise_i) begin
          sh_q  <= lsb_first_i ? {sdi_i, sh_q[BYTE_W-1:1]} : {sh_q[BYTE_W-2:0], sdi_i};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(BYTE_W - 1)) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign active_o = active_q;
  assign sdo_o    = sdo_q;
  assign done_o   = done_q;
  assign rx_o     = sh_q;

  AST_DONE_ENDS_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !active_q); // R9

endmodule

// File: rtl/ssa_buf_ram.sv
module ssa_buf_ram import ssa_pkg::*; #(
  parameter int unsigned DEPTH = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_a_i,
  input  logic [$clog2(DEPTH)-1:0] addr_a_i,
  input  logic [BYTE_W-1:0]        wd_a_i,
  output logic [BYTE_W-1:0]        rd_a_o,
  input  logic                     we_b_i,
  input  logic [$clog2(DEPTH)-1:0] addr_b_i,
  input  logic [BYTE_W-1:0]        wd_b_i,
  output logic [BYTE_W-1:0]        rd_b_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  // storage holds no reset; the valid map hides stale entries
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we_b_i && (addr_b_i == i[$clog2(DEPTH)-1:0]))
        mem_q[i] <= wd_b_i;
      else if (we_a_i && (addr_a_i == i[$clog2(DEPTH)-1:0]))
        mem_q[i] <= wd_a_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      if (we_a_i) vld_q[addr_a_i] <= 1'b1;
      if (we_b_i) vld_q[addr_b_i] <= 1'b1;
    end
  end

  assign rd_a_o = vld_q[addr_a_i] ? mem_q[addr_a_i] : '0;
  assign rd_b_o = vld_q[addr_b_i] ? mem_q[addr_b_i] : '0;

endmodule

// File: rtl/ssa_auto_seq.sv
module ssa_auto_seq import ssa_pkg::*; #(
  parameter int unsigned AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              repeat_i,
  input  logic [AW-1:0]     end_i,
  input  logic              byte_done_i,
  input  logic              rxe_i,
  input  logic [BYTE_W-1:0] rx_i,
  output logic [AW-1:0]     ctr_o,
  output logic              run_o,
  output logic              eng_start_o,
  output logic              ram_we_o,
  output logic [BYTE_W-1:0] ram_wd_o,
  output logic              pass_end_o
);
  seq_state_e    state_q;
  logic [AW-1:0] ctr_q;
  logic          at_end;
  logic          handle;

  assign handle = (state_q == SEQ_RUN) && byte_done_i;
  assign at_end = (ctr_q == end_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      ctr_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (go_i) begin
          ctr_q   <= '0;
          state_q <= SEQ_LOAD;
        end
        SEQ_LOAD: state_q <= SEQ_RUN;
        SEQ_RUN: if (byte_done_i) begin
          if (!at_end) begin
            ctr_q   <= ctr_q + 1'b1;
            state_q <= SEQ_LOAD;
          end else if (repeat_i) begin
            ctr_q   <= '0;
            state_q <= SEQ_LOAD;
          end else begin
            state_q <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // LOAD reads the entry one cycle after any write-back to it
  assign eng_start_o = (state_q == SEQ_LOAD);
  assign ram_we_o    = handle && rxe_i;
  assign ram_wd_o    = rx_i;
  assign pass_end_o  = handle && at_end;
  assign run_o       = (state_q != SEQ_IDLE);
  assign ctr_o       = ctr_q;

  AST_WRAP_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (handle && at_end && repeat_i) |=> (ctr_q == '0 && state_q == SEQ_LOAD)); // R11
  AST_SINGLE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (handle && at_end && !repeat_i) |=> (state_q == SEQ_IDLE)); // R10

endmodule

// File: rtl/sync_serial_autobuf.sv
module sync_serial_autobuf import ssa_pkg::*; #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DIV   = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [$clog2(DEPTH):0] addr_i,
  input  logic                   wr_en_i,
  input  logic [BYTE_W-1:0]      wmask_i,
  input  logic [BYTE_W-1:0]      wdata_i,
  output logic [BYTE_W-1:0]      rdata_o,
  output logic                   sck_o,
  input  logic                   sck_i,
  output logic                   sdo_o,
  input  logic                   sdi_i,
  output logic                   busy_o,
  output logic                   done_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [BYTE_W-1:0] mode_q;
  logic              en, auto_md, rpt, mst, txe, rxe, lsb;
  logic              unit_rst_n;
  logic              reg_wr, buf_wr;
  logic [1:0]        sub;
  logic [AW-1:0]     end_q;
  logic [BYTE_W-1:0] rx_q;
  logic              busy_q, done_q;
  logic              one_start, go;

  logic              eng_active, eng_done, eng_start, sdo_raw;
  logic [BYTE_W-1:0] eng_rx, eng_tx;
  logic              sck_raw, fall_stb, rise_stb;

  logic [AW-1:0]     ctr;
  logic              seq_run, seq_start, seq_we, pass_end;
  logic [BYTE_W-1:0] seq_wd, ram_rd_a, ram_rd_b;
  logic              byte1_done;

  assign en      = mode_q[M_EN];
  assign auto_md = mode_q[M_AUTO];
  assign rpt     = mode_q[M_RPT];
  assign mst     = mode_q[M_MST];
  assign txe     = mode_q[M_TXE];
  assign rxe     = mode_q[M_RXE];
  assign lsb     = mode_q[M_LSB];

  // enable bit doubles as the unit's asynchronous reset
  assign unit_rst_n = rst_ni & en;

  assign sub    = addr_i[1:0];
  assign reg_wr = wr_en_i && addr_i[AW];
  assign buf_wr = wr_en_i && !addr_i[AW] && en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      mode_q <= '0;
    else if (reg_wr && sub == REG_MODE)
      mode_q <= ((mode_q & ~wmask_i) | (wdata_i & wmask_i)) & 8'hFE;
  end

  assign one_start = reg_wr && (sub == REG_DATA) && !auto_md && !busy_q;
  assign go        = reg_wr && (sub == REG_CTRL) && auto_md && !busy_q
                     && wmask_i[0] && wdata_i[0];
  assign byte1_done = eng_done && !seq_run;

  always_ff @(posedge clk_i or negedge unit_rst_n) begin
    if (!unit_rst_n) begin
      end_q  <= '0;
      rx_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (reg_wr && sub == REG_END)
        end_q <= (end_q & ~wmask_i[AW-1:0]) | (wdata_i[AW-1:0] & wmask_i[AW-1:0]);
      if (byte1_done && rxe)
        rx_q <= eng_rx;
      if (one_start || go)
        busy_q <= 1'b1;
      else if (byte1_done || (pass_end && !rpt))
        busy_q <= 1'b0;
      done_q <= byte1_done || pass_end;
    end
  end

  assign eng_start = one_start || seq_start;
  assign eng_tx    = one_start ? wdata_i : ram_rd_b;

  ssa_sck_gen #(.DIV(DIV)) u_sck (
    .clk_i    (clk_i),
    .rst_ni   (unit_rst_n),
    .master_i (mst),
    .active_i (eng_active),
    .sck_i    (sck_i),
    .sck_o    (sck_raw),
    .fall_o   (fall_stb),
    .rise_o   (rise_stb)
  );

  ssa_shift_eng u_eng (
    .clk_i       (clk_i),
    .rst_ni      (unit_rst_n),
    .start_i     (eng_start),
    .tx_i        (eng_tx),
    .lsb_first_i (lsb),
    .fall_i      (fall_stb),
    .rise_i      (rise_stb),
    .sdi_i       (sdi_i),
    .active_o    (eng_active),
    .sdo_o       (sdo_raw),
    .done_o      (eng_done),
    .rx_o        (eng_rx)
  );

  ssa_auto_seq #(.AW(AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (unit_rst_n),
    .go_i        (go),
    .repeat_i    (rpt),
    .end_i       (end_q),
    .byte_done_i (eng_done),
    .rxe_i       (rxe),
    .rx_i        (eng_rx),
    .ctr_o       (ctr),
    .run_o       (seq_run),
    .eng_start_o (seq_start),
    .ram_we_o    (seq_we),
    .ram_wd_o    (seq_wd),
    .pass_end_o  (pass_end)
  );

  ssa_buf_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i    (clk_i),
    .rst_ni   (unit_rst_n),
    .we_a_i   (buf_wr),
    .addr_a_i (addr_i[AW-1:0]),
    .wd_a_i   (wdata_i),
    .rd_a_o   (ram_rd_a),
    .we_b_i   (seq_we),
    .addr_b_i (ctr),
    .wd_b_i   (seq_wd),
    .rd_b_o   (ram_rd_b)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i[AW]) begin
      unique case (sub)
        REG_MODE: rdata_o = mode_q;
        REG_END:  rdata_o = BYTE_W'(end_q);
        REG_DATA: rdata_o = rx_q;
        default:  rdata_o = {busy_q, {(BYTE_W-1-AW){1'b0}}, ctr};
      endcase
    end else if (en) begin
      rdata_o = ram_rd_a;
    end
  end

  assign sck_o  = !en || sck_raw;
  assign sdo_o  = en && txe && sdo_raw;
  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!unit_rst_n)
    done_q |=> !done_q); // R9
  AST_ENGINE_UNDER_BUSY: assert property (@(posedge clk_i) disable iff (!unit_rst_n)
    eng_active |-> busy_q); // R9
  AST_IDLE_SCK_HIGH: assert property (@(posedge clk_i) disable iff (!unit_rst_n)
    !busy_q |-> sck_o); // R5

endmodule

// File: tb/sync_serial_autobuf_tb_top.sv
module sync_serial_autobuf_tb_top;
  localparam int DEPTH = 32;
  localparam int DIV   = 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int BYTE_CYC = 8 * DIV;
  localparam logic [AW:0] A_MODE = (1 << AW) + 0;
  localparam logic [AW:0] A_END  = (1 << AW) + 1;
  localparam logic [AW:0] A_DATA = (1 << AW) + 2;
  localparam logic [AW:0] A_CTRL = (1 << AW) + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW:0] addr = '0;
  logic wr_en = 1'b0;
  logic [7:0] wmask = '0, wdata = '0, rdata;
  logic sck_o, sck_in = 1'b1, sdo, sdi = 1'b0, busy, done;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] mode_sh = '0;

  always #4 clk = ~clk;

  sync_serial_autobuf #(.DEPTH(DEPTH), .DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wmask_i(wmask), .wdata_i(wdata), .rdata_o(rdata),
    .sck_o(sck_o), .sck_i(sck_in), .sdo_o(sdo), .sdi_i(sdi),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW:0] a, input logic [7:0] m, input logic [7:0] d);
    @(negedge clk);
    addr = a; wmask = m; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (a == A_MODE) mode_sh = ((mode_sh & ~m) | (d & m)) & 8'hFE;
  endtask

  task automatic rd(input logic [AW:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    chk(rdata === exp, tag, rdata, exp);
  endtask

  task automatic wait_done(input int exp_n, input bit exp_busy, input string tag);
    int n = 0;
    while (!done && n < exp_n + 60) begin
      @(posedge clk); #1; n++;
    end
    chk(done === 1'b1 && n == exp_n, {tag, " done cycle"}, n, exp_n);
    chk(busy === exp_busy, {tag, " busy at done"}, busy, exp_busy);
  endtask

  task automatic pulse_low(input string tag);
    @(posedge clk); #1;
    chk(done === 1'b0, {tag, " done one cycle"}, done, 0);
  endtask

  // serial peer on the master clock line
  bit peer_on = 1'b0, peer_lsb = 1'b0;
  logic [7:0] peer_q[$];
  logic [7:0] got_q[$];
  int p_cnt = 0, r_cnt = 0;
  logic [7:0] p_cur = '0, r_sh = '0;

  task automatic peer_reset(input bit lsb_first);
    peer_q.delete(); got_q.delete();
    p_cnt = 0; r_cnt = 0; peer_lsb = lsb_first;
  endtask

  always @(negedge sck_o) if (peer_on) begin
    if (p_cnt == 0) p_cur = (peer_q.size() > 0) ? peer_q.pop_front() : 8'h00;
    sdi = peer_lsb ? p_cur[p_cnt] : p_cur[7 - p_cnt];
    p_cnt = (p_cnt + 1) % 8;
  end

  always @(posedge sck_o) if (peer_on) begin
    if (peer_lsb) r_sh[r_cnt] = sdo; else r_sh[7 - r_cnt] = sdo;
    r_cnt++;
    if (r_cnt == 8) begin got_q.push_back(r_sh); r_cnt = 0; end
  end

  task automatic got(input logic [7:0] exp, input string tag);
    logic [7:0] v;
    v = (got_q.size() > 0) ? got_q.pop_front() : 8'hxx;
    chk(v === exp, tag, v, exp);
  endtask

  // per-clock line model against the shadow mode
  bit mon_on = 1'b0;
  int done_seen = 0;
  always @(negedge clk) if (mon_on) begin
    if (done) done_seen++;
    if (!mode_sh[7])
      chk(sdo === 1'b0 && sck_o === 1'b1 && busy === 1'b0, "R2 idle lines", {sdo, sck_o, busy}, 3'b010);
    else if (!mode_sh[3])
      chk(sdo === 1'b0, "R7 sdo low when tx off", sdo, 0);
    if (mode_sh[7] && !busy)
      chk(sck_o === 1'b1, "R5 sck idle high", sck_o, 1);
  end

  task automatic toggle_en();
    wr(A_MODE, 8'h80, 8'h00);
    wr(A_MODE, 8'h80, 8'h80);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    mon_on = 1'b1;

    // R1 / R2 reset state
    rd(A_MODE, 8'h00, "R1 mode reset");
    chk(busy === 1'b0 && sdo === 1'b0 && sck_o === 1'b1, "R2 reset lines", {busy, sdo, sck_o}, 3'b001);

    // R1 byte and bit-masked writes
    wr(A_MODE, 8'hFF, 8'hFF);
    rd(A_MODE, 8'hFE, "R1 full write bit0 zero");
    wr(A_MODE, 8'h40, 8'h00);
    rd(A_MODE, 8'hBE, "R1 single bit clear");
    wr(A_MODE, 8'h02, 8'h00);
    rd(A_MODE, 8'hBC, "R1 second bit clear");
    wr(A_MODE, 8'hFF, 8'h00);

    // R4 buffer gated by enable
    wr(5'd3, 8'hFF, 8'h5A);
    rd(5'd3, 8'h00, "R4 read while disabled");
    wr(A_MODE, 8'hFF, 8'h80);
    rd(5'd3, 8'h00, "R4 write while disabled dropped");
    wr(5'd3, 8'hFF, 8'h5A);
    rd(5'd3, 8'h5A, "R4 write while enabled");
    toggle_en();
    rd(5'd3, 8'h00, "R4 contents lost over disable");

    // R13 / R3 end address
    wr(A_END, 8'hFF, 8'hFF);
    rd(A_END, 8'h1F, "R13 end upper bits zero");
    toggle_en();
    rd(A_END, 8'h00, "R3 end cleared by disable");

    // R9 / R5 / R6 one byte master, MSB first
    wr(A_MODE, 8'hFF, 8'h9C);
    peer_reset(1'b0); peer_q.push_back(8'h3C); peer_on = 1'b1;
    wr(A_DATA, 8'hFF, 8'hA5);
    wait_done(BYTE_CYC + 1, 1'b0, "R9 one byte");
    pulse_low("R9");
    got(8'hA5, "R5 R6 msb tx byte");
    rd(A_DATA, 8'h3C, "R9 R6 msb rx byte");

    // R6 LSB first
    wr(A_MODE, 8'hFF, 8'h9E);
    peer_reset(1'b1); peer_q.push_back(8'hC3);
    wr(A_DATA, 8'hFF, 8'h1E);
    wait_done(BYTE_CYC + 1, 1'b0, "R6 lsb");
    got(8'h1E, "R6 lsb tx byte");
    rd(A_DATA, 8'hC3, "R6 lsb rx byte");

    // R7 transmit off
    wr(A_MODE, 8'hFF, 8'h94);
    peer_reset(1'b0); peer_q.push_back(8'h66);
    wr(A_DATA, 8'hFF, 8'hFF);
    wait_done(BYTE_CYC + 1, 1'b0, "R7 tx off");
    got(8'h00, "R7 line low all byte");
    rd(A_DATA, 8'h66, "R7 rx still works");

    // R8 receive off
    wr(A_MODE, 8'hFF, 8'h98);
    peer_reset(1'b0); peer_q.push_back(8'h11);
    wr(A_DATA, 8'hFF, 8'h77);
    wait_done(BYTE_CYC + 1, 1'b0, "R8 rx off");
    got(8'h77, "R8 tx byte");
    rd(A_DATA, 8'h66, "R8 data kept");

    // R3 data register cleared
    peer_on = 1'b0;
    toggle_en();
    rd(A_DATA, 8'h00, "R3 data cleared");

    // R10 single automatic run over entries 0..3
    wr(A_MODE, 8'hFF, 8'hDC);
    for (int i = 0; i < 4; i++) wr(AW'(i), 8'hFF, 8'h10 + 8'(i));
    wr(A_END, 8'hFF, 8'h03);
    peer_reset(1'b0);
    for (int i = 0; i < 4; i++) peer_q.push_back(8'hE0 + 8'(i));
    peer_on = 1'b1;
    wr(A_CTRL, 8'hFF, 8'h01);
    wait_done(4 * (BYTE_CYC + 2), 1'b0, "R10 single");
    pulse_low("R10");
    for (int i = 0; i < 4; i++) got(8'h10 + 8'(i), "R10 tx entry");
    for (int i = 0; i < 4; i++) rd(AW'(i), 8'hE0 + 8'(i), "R10 entry replaced");
    rd(A_CTRL, 8'h03, "R10 stops at end address");

    // R8 receive off in automatic mode keeps buffer
    wr(A_MODE, 8'hFF, 8'hD8);
    wr(A_END, 8'hFF, 8'h00);
    peer_reset(1'b0); peer_q.push_back(8'h99);
    wr(A_CTRL, 8'hFF, 8'h01);
    wait_done(BYTE_CYC + 2, 1'b0, "R8 auto");
    got(8'hE0, "R8 auto tx");
    rd(5'd0, 8'hE0, "R8 buffer kept");

    // R11 repeat over entries 0..1
    wr(A_MODE, 8'hFF, 8'hFC);
    wr(5'd0, 8'hFF, 8'h20);
    wr(5'd1, 8'hFF, 8'h21);
    wr(A_END, 8'hFF, 8'h01);
    peer_reset(1'b0);
    for (int i = 0; i < 4; i++) peer_q.push_back(8'h30 + 8'(i));
    wr(A_CTRL, 8'hFF, 8'h01);
    wait_done(2 * (BYTE_CYC + 2), 1'b1, "R11 pass one");
    rd(A_CTRL, 8'h80, "R11 counter wrapped busy held");
    pulse_low("R11");
    wait_done(2 * (BYTE_CYC + 2) - 1, 1'b1, "R11 pass two");
    rd(5'd0, 8'h32, "R11 entry0 pass two");
    rd(5'd1, 8'h33, "R11 entry1 pass two");
    got(8'h20, "R11 tx p1 e0");
    got(8'h21, "R11 tx p1 e1");
    got(8'h30, "R11 tx p2 e0");
    got(8'h31, "R11 tx p2 e1");
    peer_on = 1'b0;
    wr(A_MODE, 8'h80, 8'h00);
    chk(busy === 1'b0 && sck_o === 1'b1 && sdo === 1'b0, "R2 R3 disable mid run", {busy, sck_o, sdo}, 3'b010);
    rd(A_CTRL, 8'h00, "R3 counter and busy cleared");
    wr(A_MODE, 8'h80, 8'h80);
    rd(5'd0, 8'h00, "R4 buffer lost");

    // R12 slave one byte, MSB first
    wr(A_MODE, 8'hFF, 8'h8C);
    done_seen = 0;
    wr(A_DATA, 8'hFF, 8'h96);
    begin
      logic [7:0] cap, rx_b;
      cap = '0; rx_b = 8'h4B;
      for (int b = 0; b < 8; b++) begin
        sck_in = 1'b0; sdi = rx_b[7 - b];
        repeat (8) @(posedge clk);
        #1;
        cap[7 - b] = sdo;
        chk(sck_o === 1'b1, "R12 sck_o stays high", sck_o, 1);
        sck_in = 1'b1;
        repeat (8) @(posedge clk);
        #1;
      end
      chk(cap === 8'h96, "R12 slave tx byte", cap, 8'h96);
    end
    chk(done_seen == 1 && busy === 1'b0, "R12 slave done once", done_seen, 1);
    rd(A_DATA, 8'h4B, "R12 slave rx byte");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule